// File: doc/BRIEF.md
# Three-Channel Sigma-Delta Decimation Interface

This block turns three one-bit sigma-delta bitstreams into 16-bit samples for a power-converter control loop. The three channels carry the output bus voltage, the phase-A inductor current and the phase-B inductor current. The block generates the modulator clock itself by dividing the system clock. It samples each bitstream once per modulator period and passes every stream through its own third-order comb-integrator (sinc3) decimator with a ratio of 128. With a 20 MHz modulator bit rate this gives roughly 156 kHz output samples.

All three filters share one modulator clock, one bit counter and one decimation counter. Their results therefore describe the same instant and are published together on one strobe that is a single system cycle wide. The output is unsigned offset binary: a stream that is one half of the time gives mid-scale. Full scale saturates instead of wrapping. The first three decimated results after reset are withheld while the filter history fills.

Samples come out at a fixed rate set by the modulator, so the output has no back-pressure. The valid strobe has no ready partner, and the consumer must capture all three words in the strobe cycle. The words then hold until the next strobe.

Top module: `sd_decim_hub`

## Requirements
- R1: `mclk_o` is low while reset is applied. After reset it is a square wave whose high and low levels each last exactly MCLK_HALF system cycles. Each bitstream input is sampled on the system clock edge at which `mclk_o` falls.
- R2: Each sample output depends only on its own bitstream input. Different patterns on the three inputs produce the matching, different results on the three outputs at the same strobe.
- R3: A stream of constant ones yields 0xFFFF on every published sample, however long it runs. The result saturates and never wraps.
- R4: `valid_o` is high for exactly one system cycle. Consecutive strobes are exactly RATIO modulator periods (2*MCLK_HALF*RATIO system cycles) apart.
- R5: Once settled, a periodic stream with ones density k/4 gives min(k*16384, 65535). So constant zeros give 0x0000, a 1010 pattern gives 0x8000, density 1/4 gives 0x4000 and density 3/4 gives 0xC000.
- R6: The first three decimated results after reset are not published. The first strobe marks the fourth decimation boundary, about 4*RATIO*2*MCLK_HALF system cycles after reset is released. The value it carries is already exact.
- R7: Synchronous reset drives all three sample outputs to zero and `valid_o` low, and clears every filter register. After a reset in mid-run, the block produces exactly the same samples as after power-up.
- R8: The three sample outputs change only in a cycle in which `valid_o` is high. They hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mclk_o | output | 1 | Modulator clock driven to the three modulators |
| bs_volt_i | input | 1 | Bitstream of the output bus voltage modulator |
| bs_ia_i | input | 1 | Bitstream of the phase-A inductor current modulator |
| bs_ib_i | input | 1 | Bitstream of the phase-B inductor current modulator |
| volt_o | output | 16 | Bus voltage sample, unsigned offset binary |
| ia_o | output | 16 | Phase-A current sample, unsigned offset binary |
| ib_o | output | 16 | Phase-B current sample, unsigned offset binary |
| valid_o | output | 1 | One-cycle strobe marking a new coherent set of three samples |

## Verification
Several conditions cannot be forced directly from the ports: the third integrator wrapping many times while the comb still recovers a saturated full-scale value, and a reset arriving in mid-run so that stale history must vanish. The stimulus reaches them by keeping an all-ones stream running for many output periods, and by resetting right after a strobe, which is then followed by a first-sample comparison. Pattern changes are applied just after a strobe. The scoreboard marks the next three results as settling and compares every later result exactly against the density formula. A missing or extra settling stage, or a wrong decimation phase, therefore shows up as a value mismatch.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

  // Integrator width that holds RATIO**ORDER growth plus the input bit.
  function automatic int cic_acc_w(input int ratio, input int order);
    return order * $clog2(ratio) + 1;
  endfunction

  // Right shift that maps the full filter range onto the output width,
  // leaving one guard bit so that full scale can be detected and saturated.
  function automatic int cic_shift(input int ratio, input int order, input int out_w);
    return cic_acc_w(ratio, order) - 1 - out_w;
  endfunction

endpackage

// File: rtl/sdd_mclk_gen.sv
module sdd_mclk_gen #(
  parameter int MCLK_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic mclk_o,
  output logic bit_en_o
);
  localparam int CW = (MCLK_HALF > 1) ? $clog2(MCLK_HALF) : 1;

  logic [CW-1:0] phase_cnt;
  logic          phase_last;

  assign phase_last = (phase_cnt == CW'(MCLK_HALF - 1));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_cnt <= '0;
      mclk_o    <= 1'b0;
    end else if (phase_last) begin
      phase_cnt <= '0;
      mclk_o    <= ~mclk_o;
    end else begin
      phase_cnt <= phase_cnt + 1'b1;
    end
  end

  // Last system cycle of the high phase: the modulator bit has been stable
  // for a full half period, so the falling-edge clock samples it.
  assign bit_en_o = mclk_o & phase_last;

endmodule

// File: rtl/sdd_frame_ctrl.sv
module sdd_frame_ctrl #(
  parameter int RATIO  = 128,
  parameter int SETTLE = 3
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic bit_en_i,
  output logic dec_tick_o,
  output logic publish_o
);
  localparam int RW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam int SW = $clog2(SETTLE + 2);

  logic [RW-1:0] bit_cnt;
  logic [SW-1:0] settle_cnt;
  logic          settled;

  assign dec_tick_o = bit_en_i && (bit_cnt == RW'(RATIO - 1));
  assign settled    = (settle_cnt == SW'(SETTLE));
  assign publish_o  = dec_tick_o && settled;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      bit_cnt    <= '0;
      settle_cnt <= '0;
    end else begin
      if (bit_en_i) begin
        bit_cnt <= dec_tick_o ? '0 : bit_cnt + 1'b1;
      end
      if (dec_tick_o && !settled) begin
        settle_cnt <= settle_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sdd_cic_chan.sv
module sdd_cic_chan #(
  parameter int ORDER = 3,
  parameter int RATIO = 128,
  parameter int OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             bit_en_i,
  input  logic             bit_i,
  input  logic             dec_tick_i,
  input  logic             publish_i,
  output logic [OUT_W-1:0] samp_o
);
  localparam int ACC_W = sdd_pkg::cic_acc_w(RATIO, ORDER);
  localparam int SHIFT = sdd_pkg::cic_shift(RATIO, ORDER, OUT_W);
  localparam int SCL_W = ACC_W - SHIFT;

  logic [ACC_W-1:0] integ    [ORDER];
  logic [ACC_W-1:0] comb_dly [ORDER];
  logic [ACC_W-1:0] comb_val [ORDER+1];
  logic [SCL_W-1:0] scaled;
  logic [OUT_W-1:0] sat_val;

  // Integrator cascade, wrap-around arithmetic, one step per modulator bit.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int k = 0; k < ORDER; k++) integ[k] <= '0;
    end else if (bit_en_i) begin
      integ[0] <= integ[0] + ACC_W'(bit_i);
      for (int k = 1; k < ORDER; k++) integ[k] <= integ[k] + integ[k-1];
    end
  end

  // Comb cascade evaluated at the decimated rate.
  always_comb begin
    comb_val[0] = integ[ORDER-1];
    for (int k = 0; k < ORDER; k++) comb_val[k+1] = comb_val[k] - comb_dly[k];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int k = 0; k < ORDER; k++) comb_dly[k] <= '0;
    end else if (dec_tick_i) begin
      for (int k = 0; k < ORDER; k++) comb_dly[k] <= comb_val[k];
    end
  end

  // Scale to the output width; the guard bit flags the single full-scale code.
  assign scaled  = comb_val[ORDER][ACC_W-1:SHIFT];
  assign sat_val = scaled[SCL_W-1] ? {OUT_W{1'b1}} : scaled[OUT_W-1:0];

  always_ff @(posedge clk_i) begin
    if (rst_i) samp_o <= '0;
    else if (publish_i) samp_o <= sat_val;
  end

endmodule

// File: rtl/sd_decim_hub.sv
module sd_decim_hub #(
  parameter int MCLK_HALF = 2,
  parameter int RATIO     = 128,
  parameter int ORDER     = 3,
  parameter int OUT_W     = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  output logic             mclk_o,
  input  logic             bs_volt_i,
  input  logic             bs_ia_i,
  input  logic             bs_ib_i,
  output logic [OUT_W-1:0] volt_o,
  output logic [OUT_W-1:0] ia_o,
  output logic [OUT_W-1:0] ib_o,
  output logic             valid_o
);
  localparam int NCH = 3;

  logic             bit_en;
  logic             dec_tick;
  logic             publish;
  logic [NCH-1:0]   bs_vec;
  logic [OUT_W-1:0] samp [NCH];

  assign bs_vec = {bs_ib_i, bs_ia_i, bs_volt_i};

  sdd_mclk_gen #(.MCLK_HALF(MCLK_HALF)) u_mclk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .mclk_o   (mclk_o),
    .bit_en_o (bit_en)
  );

  sdd_frame_ctrl #(.RATIO(RATIO), .SETTLE(ORDER)) u_frame (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .bit_en_i   (bit_en),
    .dec_tick_o (dec_tick),
    .publish_o  (publish)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    sdd_cic_chan #(.ORDER(ORDER), .RATIO(RATIO), .OUT_W(OUT_W)) u_cic (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .bit_en_i   (bit_en),
      .bit_i      (bs_vec[g]),
      .dec_tick_i (dec_tick),
      .publish_i  (publish),
      .samp_o     (samp[g])
    );
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) valid_o <= 1'b0;
    else       valid_o <= publish;
  end

  assign volt_o = samp[0];
  assign ia_o   = samp[1];
  assign ib_o   = samp[2];

endmodule

// File: rtl/sdd_checker.sv
module sdd_checker #(
  parameter int MCLK_HALF = 2,
  parameter int RATIO     = 128,
  parameter int OUT_W     = 16
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             mclk_o,
  input logic [OUT_W-1:0] volt_o,
  input logic [OUT_W-1:0] ia_o,
  input logic [OUT_W-1:0] ib_o,
  input logic             valid_o
);
  localparam int PER = 2 * MCLK_HALF * RATIO;
  localparam int GW  = $clog2(PER) + 4;
  localparam int HW  = $clog2(MCLK_HALF + 2) + 1;

  logic          seen;
  logic          prev_m;
  logic          m_armed;
  logic [HW-1:0] lvl_cnt;
  logic          v_armed;
  logic [GW-1:0] gap;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      seen    <= 1'b0;
      prev_m  <= 1'b0;
      m_armed <= 1'b0;
      lvl_cnt <= '0;
      v_armed <= 1'b0;
      gap     <= '0;
    end else begin
      seen   <= 1'b1;
      prev_m <= mclk_o;
      if (mclk_o != prev_m) begin
        lvl_cnt <= HW'(1);
        m_armed <= 1'b1;
      end else begin
        lvl_cnt <= lvl_cnt + 1'b1;
      end
      if (valid_o) begin
        gap     <= GW'(1);
        v_armed <= 1'b1;
      end else begin
        gap <= gap + 1'b1;
      end
    end
  end

  // R1: every level of the modulator clock lasts MCLK_HALF cycles
  assert_mclk_half_R1: assert property (@(posedge clk_i) disable iff (rst_i || !seen)
    (m_armed && (mclk_o != prev_m)) |-> (lvl_cnt == HW'(MCLK_HALF)));

  // R4: strobe is a single cycle wide
  assert_valid_single_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |=> !valid_o);

  // R4: strobes are one decimation period apart
  assert_valid_spacing_R4: assert property (@(posedge clk_i) disable iff (rst_i || !seen)
    (valid_o && v_armed) |-> (gap == GW'(PER)));

  // R8: outputs hold between strobes
  assert_hold_between_R8: assert property (@(posedge clk_i) disable iff (rst_i || !seen)
    !valid_o |-> $stable({volt_o, ia_o, ib_o}));

  // R7: leaving reset, everything is cleared
  assert_reset_clear_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rst_i) |-> (volt_o == '0 && ia_o == '0 && ib_o == '0 && !valid_o && !mclk_o));

endmodule

bind sd_decim_hub sdd_checker #(
  .MCLK_HALF(MCLK_HALF),
  .RATIO    (RATIO),
  .OUT_W    (OUT_W)
) u_sdd_checker (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .mclk_o  (mclk_o),
  .volt_o  (volt_o),
  .ia_o    (ia_o),
  .ib_o    (ib_o),
  .valid_o (valid_o)
);

// File: tb/tb_sd_decim_hub.sv
module tb_sd_decim_hub;
  localparam int HALF  = 2;
  localparam int RATIO = 128;
  localparam int PER   = 2 * HALF * RATIO;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bs_v = 1'b0, bs_a = 1'b0, bs_b = 1'b0;
  logic mclk, valid;
  logic [15:0] v_o, a_o, b_o;

  always #4 clk = ~clk;

  sd_decim_hub dut (
    .clk_i(clk), .rst_i(rst), .mclk_o(mclk),
    .bs_volt_i(bs_v), .bs_ia_i(bs_a), .bs_ib_i(bs_b),
    .volt_o(v_o), .ia_o(a_o), .ib_o(b_o), .valid_o(valid)
  );

  int errors = 0;
  int checks = 0;

  typedef struct {
    bit          chk;
    logic [15:0] e0, e1, e2;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  logic [3:0] pat0 = '0, pat1 = '0, pat2 = '0;
  int first_lat = -1;

  task automatic check_val(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] dens(input logic [3:0] p);
    int s;
    s = $countones(p) * 16384;
    return (s > 65535) ? 16'hFFFF : 16'(s);
  endfunction

  // Driver side of the scoreboard: queue the expected results of one segment.
  task automatic push_seg(input logic [3:0] p0, p1, p2, input int skip, input int n,
                          input string req);
    pat0 = p0; pat1 = p1; pat2 = p2;
    for (int i = 0; i < skip + n; i++) begin
      exp_t e;
      e.chk = (i >= skip);
      e.e0 = dens(p0); e.e1 = dens(p1); e.e2 = dens(p2);
      e.req = req;
      exp_q.push_back(e);
    end
  endtask

  task automatic run_seg(input logic [3:0] p0, p1, p2, input int skip, input int n,
                         input string req);
    push_seg(p0, p1, p2, skip, n, req);
    wait (exp_q.size() == 0);
  endtask

  task automatic reset_checks(input string req);
    check_val(req, "volt in reset", 32'(v_o), 0);
    check_val(req, "ia in reset", 32'(a_o), 0);
    check_val(req, "ib in reset", 32'(b_o), 0);
    check_val(req, "valid in reset", 32'(valid), 0);
    check_val("R1", "mclk in reset", 32'(mclk), 0);
  endtask

  // Modulator model: a new bit after each rising edge of the modulator clock.
  initial begin
    int idx;
    logic pm;
    idx = 0;
    pm = 1'b0;
    forever begin
      @(negedge clk);
      if (mclk && !pm) begin
        bs_v <= pat0[idx];
        bs_a <= pat1[idx];
        bs_b <= pat2[idx];
        idx = (idx + 1) % 4;
      end
      pm = mclk;
    end
  end

  // Monitor side of the scoreboard.
  initial begin
    int mrises, cyc;
    bit have_prev, prev_valid, hold_bad;
    logic pm;
    logic [47:0] last_out;
    mrises = 0; cyc = 0; have_prev = 0; prev_valid = 0; hold_bad = 0; pm = 0;
    last_out = '0;
    forever begin
      @(negedge clk);
      if (rst) begin
        mrises = 0; cyc = 0; have_prev = 0; prev_valid = 0; hold_bad = 0;
        first_lat = -1;
        pm = mclk;
      end else begin
        cyc++;
        if (mclk && !pm) mrises++;
        pm = mclk;
        if (valid) begin
          exp_t e;
          if (first_lat < 0) first_lat = cyc;
          check_val("R4", "valid one cycle wide", 32'(prev_valid), 0);
          if (have_prev) check_val("R4", "modulator periods per sample", 32'(mrises), RATIO);
          check_val("R8", "outputs held between strobes", 32'(hold_bad), 0);
          mrises = 0; have_prev = 1; hold_bad = 0;
          if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R4 unexpected strobe: actual=1 expected=0");
          end else begin
            e = exp_q.pop_front();
            if (e.chk) begin
              check_val(e.req, "volt sample", 32'(v_o), 32'(e.e0));
              check_val(e.req, "ia sample",   32'(a_o), 32'(e.e1));
              check_val(e.req, "ib sample",   32'(b_o), 32'(e.e2));
            end
          end
        end else if ({v_o, a_o, b_o} !== last_out) begin
          hold_bad = 1;
        end
        prev_valid = valid;
      end
      last_out = {v_o, a_o, b_o};
    end
  end

  initial begin
    fork
      begin
        int hcnt, lcnt;
        repeat (4) @(negedge clk);
        reset_checks("R7");
        // R5 R2 R6: distinct densities, first published sample already exact
        push_seg(4'b0101, 4'b0001, 4'b0111, 0, 6, "R5");
        @(negedge clk);
        rst = 1'b0;
        // R1: high and low levels of the modulator clock
        while (mclk) @(negedge clk);
        while (!mclk) @(negedge clk);
        hcnt = 0;
        while (mclk) begin hcnt++; @(negedge clk); end
        lcnt = 0;
        while (!mclk) begin lcnt++; @(negedge clk); end
        check_val("R1", "mclk high cycles", 32'(hcnt), HALF);
        check_val("R1", "mclk low cycles", 32'(lcnt), HALF);
        wait (exp_q.size() == 0);
        check_val("R6", "first strobe latency in window",
                  32'((first_lat >= 4*PER - 8) && (first_lat <= 4*PER + 8)), 1);
        // R3: full scale saturates over a long run; R2 channels differ
        run_seg(4'b1111, 4'b0000, 4'b0011, 3, 10, "R3");
        run_seg(4'b0000, 4'b1111, 4'b0001, 3, 6, "R2");
        // R7: reset in mid-run, then results identical to power-up
        @(negedge clk);
        rst = 1'b1;
        repeat (4) @(negedge clk);
        reset_checks("R7");
        push_seg(4'b0111, 4'b0101, 4'b1111, 0, 4, "R7");
        rst = 1'b0;
        wait (exp_q.size() == 0);
        check_val("R7", "first strobe latency after mid-run reset",
                  32'((first_lat >= 4*PER - 8) && (first_lat <= 4*PER + 8)), 1);
      end
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R4 watchdog: actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule